// File: doc/BRIEF.md
# Nine-Bit Serial Register File Slave

This block is a serial slave that lets a host processor program the 16-bit control registers of a display bridge. Every host word is nine bits long. The first bit shifted in says whether the word is an address (command) cycle or a data cycle, and the eight bits after it carry the byte. A register write takes three words: an address cycle, the low byte, then the high byte. A read-back is a guarded transaction. It is armed first, and one nine-bit trigger word then makes the slave shift the chosen register out on MISO.

A second path streams packet payload. An address cycle naming the stream register opens a stream. Each data byte that follows is presented on a byte output with a one-cycle strobe, until the programmed length runs out. The serial inputs are brought into the system clock through synchronisers, and the whole block runs on that clock.

Top module: `spi9_regfile`

## Requirements
- R1: A word is nine bits, shifted in MSB first on rising SCK while chip select is low (SPI mode 0). The first bit is 0 for an address cycle and 1 for a data cycle. Out of reset MISO, the payload strobe and the done pulse are all 0.
- R2: A write is an address cycle, a data cycle with bits 7:0, then a data cycle with bits 15:8. The register keeps its old value until the high byte has arrived.
- R3: Data cycles that arrive before any address cycle since reset change no register and produce no payload strobe.
- R4: A data byte that follows a completed high-byte write starts a new low byte for the same address.
- R5: Writing 0x00FA to address 0xD4 and then sending an address cycle with the target arms a read. An address cycle carrying 0xFA then makes the slave return the target register on MISO. It sends 16 bits, high byte first, one bit after each falling SCK, to be sampled on the next rising edge.
- R6: A 0xFA trigger returns 0x0000 when no read is armed, and each trigger uses up the arming.
- R7: Address 0xB0 reads as the identification value 0x5A31 and ignores writes. Writes outside 0xB0..0xEB are ignored, and reads of such addresses return 0x0000.
- R8: Writing 0x0100 to address 0xC0 returns every other register to its default (zero, with the identification value unchanged), while 0xC0 keeps the written value. Any other value written to 0xC0 resets nothing.
- R9: Address 0xDE accepts only values 0 to 3. A larger value leaves it unchanged.
- R10: An address cycle with 0xBF loads the stream count from register 0xBC. Each later data byte produces one strobe cycle carrying that byte, in order, while the count is non-zero. The done pulse comes together with the last counted byte, and bytes after that are dropped.
- R11: Raising chip select in the middle of a word discards the partial word, and the next word is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select framing each transfer |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read-back data to the host |
| pay_byte | output | 8 | Current payload byte |
| pay_valid | output | 1 | One-cycle strobe qualifying pay_byte |
| pay_done | output | 1 | One-cycle pulse with the last byte of a stream |

## Verification
The assertions assume SCK runs no faster than a quarter of the system clock, so that two detected rising edges never fall in adjacent cycles. They also assume MOSI only changes while SCK is low. The bench drives SCK with a four-cycle half period and changes MOSI a full half period before each rising edge. It samples MISO just before the rising edge. That leaves room for the three cycles between a falling SCK and new MISO data: two synchroniser stages and one output register.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;

  localparam logic [BYTE_W-1:0] READ_CODE   = 8'hFA;
  localparam logic [BYTE_W-1:0] ID_ADDR     = 8'hB0;
  localparam logic [BYTE_W-1:0] LEN_ADDR    = 8'hBC;
  localparam logic [BYTE_W-1:0] STREAM_ADDR = 8'hBF;
  localparam logic [BYTE_W-1:0] OPCTL_ADDR  = 8'hC0;
  localparam logic [BYTE_W-1:0] RDCTL_ADDR  = 8'hD4;
  localparam logic [BYTE_W-1:0] LANE_ADDR   = 8'hDE;

  localparam logic [REG_W-1:0] ARM_VAL      = 16'h00FA;
  localparam logic [REG_W-1:0] SOFT_RST_VAL = 16'h0100;
  localparam logic [REG_W-1:0] LANE_MAX     = 16'd3;

  typedef struct packed {
    logic              is_data;
    logic [BYTE_W-1:0] data;
  } spi9_word_t;
endpackage

// File: rtl/spi9_sync.sv
module spi9_sync #(
  parameter int               STAGES  = 2,
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/spi9_shifter.sv
module spi9_shifter
  import spi9_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_s,
  input  logic             csn_s,
  input  logic             mosi_s,
  input  logic [REG_W-1:0] rd_data,
  output logic             word_valid,
  output spi9_word_t       word,
  output logic             miso
);
  localparam int BIT_W   = $clog2(BYTE_W + 1);
  localparam int TX_W    = $clog2(REG_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);
  localparam logic [TX_W-1:0]  LAST_TX  = TX_W'(REG_W - 1);

  logic                sck_q;
  logic [BIT_W-1:0]    bit_cnt;
  logic [BYTE_W-1:0]   rx_sh;
  logic                tx_active;
  logic [TX_W-1:0]     tx_cnt;
  logic [REG_W-1:0]    tx_sh;
  logic                miso_q;
  logic                rise, fall;
  logic [BYTE_W:0]     nxt;

  assign rise = sck_s & ~sck_q & ~csn_s;
  assign fall = ~sck_s & sck_q & ~csn_s;
  assign nxt  = {rx_sh, mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q      <= 1'b0;
      bit_cnt    <= '0;
      rx_sh      <= '0;
      tx_active  <= 1'b0;
      tx_cnt     <= '0;
      tx_sh      <= '0;
      miso_q     <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      sck_q      <= sck_s;
      word_valid <= 1'b0;
      if (csn_s) begin
        bit_cnt   <= '0;
        tx_active <= 1'b0;
        miso_q    <= 1'b0;
      end else if (rise) begin
        if (tx_active) begin
          tx_cnt <= tx_cnt + 1'b1;
          if (tx_cnt == LAST_TX) tx_active <= 1'b0;
        end else if (bit_cnt == LAST_BIT) begin
          bit_cnt      <= '0;
          word_valid   <= 1'b1;
          word.is_data <= nxt[BYTE_W];
          word.data    <= nxt[BYTE_W-1:0];
          if (!nxt[BYTE_W] && nxt[BYTE_W-1:0] == READ_CODE) begin
            tx_active <= 1'b1;
            tx_cnt    <= '0;
            tx_sh     <= rd_data;
          end
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          rx_sh   <= nxt[BYTE_W-1:0];
        end
      end else if (fall && tx_active) begin
        miso_q <= tx_sh[REG_W-1];
        tx_sh  <= {tx_sh[REG_W-2:0], 1'b0};
      end
    end
  end

  assign miso = miso_q;

  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= LAST_BIT); // R1
  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid); // R1
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> (bit_cnt == '0 && !tx_active)); // R11
endmodule

// File: rtl/spi9_regbank.sv
module spi9_regbank
  import spi9_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ADDR_LO = 8'hB0,
  parameter logic [BYTE_W-1:0] ADDR_HI = 8'hEB,
  parameter logic [REG_W-1:0]  DEV_ID  = 16'h5A31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  spi9_word_t        word,
  output logic [REG_W-1:0]  rd_data,
  output logic [BYTE_W-1:0] pay_byte,
  output logic              pay_valid,
  output logic              pay_done
);
  localparam int NREG     = int'(ADDR_HI) - int'(ADDR_LO) + 1;
  localparam int IDX_W    = $clog2(NREG);
  localparam int ID_IDX   = int'(ID_ADDR) - int'(ADDR_LO);
  localparam int OPC_IDX  = int'(OPCTL_ADDR) - int'(ADDR_LO);
  localparam int LEN_IDX  = int'(LEN_ADDR) - int'(ADDR_LO);
  localparam int LANE_IDX = int'(LANE_ADDR) - int'(ADDR_LO);

  function automatic logic in_range(input logic [BYTE_W-1:0] a);
    return (a >= ADDR_LO) && (a <= ADDR_HI);
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] d;
    d = a - ADDR_LO;
    return d[IDX_W-1:0];
  endfunction

  logic [REG_W-1:0]  regs [NREG];
  logic              have_addr, phase_hi, stream_on, arm_pend, armed_q;
  logic [BYTE_W-1:0] addr_ptr, low_hold, arm_addr;
  logic [REG_W-1:0]  rem_q, rd_q;
  logic              cmd, dat, is_rdcode, wr_en, wr_ok, soft_rst;
  logic [REG_W-1:0]  wr_val;
  logic [IDX_W-1:0]  wr_idx;

  assign cmd       = word_valid & ~word.is_data;
  assign dat       = word_valid & word.is_data;
  assign is_rdcode = (word.data == READ_CODE);
  assign wr_en     = dat & have_addr & ~stream_on & phase_hi;
  assign wr_val    = {word.data, low_hold};
  assign wr_idx    = idx_of(addr_ptr);
  assign wr_ok     = wr_en && in_range(addr_ptr) && (addr_ptr != ID_ADDR) &&
                     !((addr_ptr == LANE_ADDR) && (wr_val > LANE_MAX));
  assign soft_rst  = wr_ok && (addr_ptr == OPCTL_ADDR) && (wr_val == SOFT_RST_VAL);

  for (genvar g = 0; g < NREG; g++) begin : gen_reg
    if (g == ID_IDX) begin : g_ro
      assign regs[g] = DEV_ID;
    end else begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || (soft_rst && g != OPC_IDX)) regs[g] <= '0;
        else if (wr_ok && wr_idx == IDX_W'(g)) regs[g] <= wr_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_addr <= 1'b0;
      phase_hi  <= 1'b0;
      stream_on <= 1'b0;
      arm_pend  <= 1'b0;
      armed_q   <= 1'b0;
      addr_ptr  <= '0;
      low_hold  <= '0;
      arm_addr  <= '0;
      rem_q     <= '0;
      rd_q      <= '0;
      pay_valid <= 1'b0;
      pay_done  <= 1'b0;
      pay_byte  <= '0;
    end else begin
      pay_valid <= 1'b0;
      pay_done  <= 1'b0;
      rd_q      <= (armed_q && in_range(arm_addr)) ? regs[idx_of(arm_addr)] : '0;
      if (cmd) begin
        if (is_rdcode) begin
          armed_q <= 1'b0;
        end else begin
          have_addr <= 1'b1;
          addr_ptr  <= word.data;
          phase_hi  <= 1'b0;
          stream_on <= (word.data == STREAM_ADDR);
          if (word.data == STREAM_ADDR) rem_q <= regs[LEN_IDX];
          if (arm_pend) begin
            armed_q  <= 1'b1;
            arm_addr <= word.data;
            arm_pend <= 1'b0;
          end
        end
      end else if (dat && have_addr) begin
        if (stream_on) begin
          if (rem_q != '0) begin
            pay_valid <= 1'b1;
            pay_byte  <= word.data;
            pay_done  <= (rem_q == REG_W'(1));
            rem_q     <= rem_q - 1'b1;
          end
        end else if (!phase_hi) begin
          low_hold <= word.data;
          phase_hi <= 1'b1;
        end else begin
          phase_hi <= 1'b0;
          if (wr_ok && addr_ptr == RDCTL_ADDR && wr_val == ARM_VAL) arm_pend <= 1'b1;
        end
      end
    end
  end

  assign rd_data = rd_q;

  AST_DONE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    pay_done |-> pay_valid); // R10
  AST_STREAM_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    pay_valid |-> (rem_q == $past(rem_q) - 1'b1)); // R10
  AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    regs[LANE_IDX] <= LANE_MAX); // R9
  AST_ARM_SPENT: assert property (@(posedge clk) disable iff (rst)
    (cmd && is_rdcode) |=> !armed_q); // R6
endmodule

// File: rtl/spi9_regfile.sv
module spi9_regfile
  import spi9_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [BYTE_W-1:0] ADDR_LO     = 8'hB0,
  parameter logic [BYTE_W-1:0] ADDR_HI     = 8'hEB,
  parameter logic [REG_W-1:0]  DEV_ID      = 16'h5A31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [BYTE_W-1:0] pay_byte,
  output logic              pay_valid,
  output logic              pay_done
);
  logic [2:0]       sync_out;
  logic             word_valid;
  spi9_word_t       word;
  logic [REG_W-1:0] rd_data;

  spi9_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({spi_sck, spi_cs_n, spi_mosi}),
    .d_out (sync_out)
  );

  spi9_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .sck_s      (sync_out[2]),
    .csn_s      (sync_out[1]),
    .mosi_s     (sync_out[0]),
    .rd_data    (rd_data),
    .word_valid (word_valid),
    .word       (word),
    .miso       (spi_miso)
  );

  spi9_regbank #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .DEV_ID(DEV_ID)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word       (word),
    .rd_data    (rd_data),
    .pay_byte   (pay_byte),
    .pay_valid  (pay_valid),
    .pay_done   (pay_done)
  );
endmodule

// File: tb/spi9_regfile_test.sv
module spi9_regfile_test;
  logic clk = 1'b0, rst = 1'b1, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso, pay_valid, pay_done;
  logic [7:0] pay_byte;
  int errs = 0, checks = 0;
  int pay_cnt = 0, done_cnt = 0;
  logic [7:0] pay_log [32];

  always #5 clk = ~clk;

  spi9_regfile uut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .pay_byte(pay_byte), .pay_valid(pay_valid), .pay_done(pay_done)
  );

  always @(negedge clk) begin
    if (!rst && pay_valid) begin
      if (pay_cnt < 32) pay_log[pay_cnt] = pay_byte;
      pay_cnt++;
      if (pay_done) done_cnt++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b);
    mosi = b; tick(4); sck = 1'b1; tick(4); sck = 1'b0;
  endtask

  task automatic word(input logic t, input logic [7:0] b);
    cs_n = 1'b0; tick(2);
    sbit(t);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    tick(4); cs_n = 1'b1; tick(6);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] v);
    word(1'b0, a); word(1'b1, v[7:0]); word(1'b1, v[15:8]);
  endtask

  task automatic rd_raw(output logic [15:0] v);
    logic [7:0] code;
    code = 8'hFA;
    cs_n = 1'b0; tick(2);
    sbit(1'b0);
    for (int i = 7; i >= 0; i--) sbit(code[i]);
    v = '0;
    for (int i = 0; i < 16; i++) begin
      tick(4); v = {v[14:0], miso}; sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(4); cs_n = 1'b1; tick(6);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    wr(8'hD4, 16'h00FA); word(1'b0, a); rd_raw(v);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic skip_addr(input int a);
    return a == 'hBF || a == 'hC0 || a == 'hD4 || a == 'hDE;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog got=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    tick(5); rst = 1'b0; tick(3);
    chk("R1 reset miso", {15'd0, miso}, 16'd0);
    chk("R1 reset pay_valid", {15'd0, pay_valid}, 16'd0);
    chk("R1 reset pay_done", {15'd0, pay_done}, 16'd0);

    rd_raw(v); chk("R6 unarmed read", v, 16'h0000);

    word(1'b1, 8'h12); word(1'b1, 8'h34);
    chk("R3 stray data no strobe", 16'(pay_cnt), 16'd0);
    rd(8'hB5, v); chk("R3 stray data no write", v, 16'h0000);

    rd(8'hB0, v); chk("R7 id value", v, 16'h5A31);
    wr(8'hB0, 16'hFFFF); rd(8'hB0, v); chk("R7 id read-only", v, 16'h5A31);
    wr(8'hAF, 16'h1234); rd(8'hAF, v); chk("R7 below range", v, 16'h0000);
    rd(8'hEC, v); chk("R7 above range", v, 16'h0000);

    // R2 / R5: sweep every writable address, value from the address
    for (int a = 'hB1; a <= 'hEB; a++)
      if (!skip_addr(a)) wr(8'(a), {8'(a), 8'(a) ^ 8'hC3});
    for (int a = 'hB1; a <= 'hEB; a++)
      if (!skip_addr(a)) begin
        rd(8'(a), v); chk("R2 R5 sweep readback", v, {8'(a), 8'(a) ^ 8'hC3});
      end

    rd_raw(v); chk("R6 arming spent", v, 16'h0000);

    wr(8'hB6, 16'h1111);
    word(1'b0, 8'hB6); word(1'b1, 8'h22);
    rd(8'hB6, v); chk("R2 low byte alone", v, 16'h1111);

    word(1'b0, 8'hB7);
    word(1'b1, 8'h01); word(1'b1, 8'h02); word(1'b1, 8'h03); word(1'b1, 8'h04);
    rd(8'hB7, v); chk("R4 continued write", v, 16'h0403);
    word(1'b0, 8'hB7);
    word(1'b1, 8'h05); word(1'b1, 8'h06); word(1'b1, 8'h07);
    rd(8'hB7, v); chk("R4 trailing low byte", v, 16'h0605);

    wr(8'hDE, 16'd2); rd(8'hDE, v); chk("R9 lane 2", v, 16'd2);
    wr(8'hDE, 16'd5); rd(8'hDE, v); chk("R9 lane 5 rejected", v, 16'd2);
    wr(8'hDE, 16'd3); rd(8'hDE, v); chk("R9 lane 3", v, 16'd3);

    cs_n = 1'b0; tick(2);
    sbit(1'b1); sbit(1'b0); sbit(1'b1); sbit(1'b1);
    tick(4); cs_n = 1'b1; tick(6);
    wr(8'hB8, 16'hBEEF); rd(8'hB8, v); chk("R11 abort then write", v, 16'hBEEF);

    base = pay_cnt;
    wr(8'hBC, 16'd3); word(1'b0, 8'hBF);
    for (int i = 0; i < 5; i++) word(1'b1, 8'hA1 + 8'(i));
    chk("R10 strobe count", 16'(pay_cnt - base), 16'd3);
    for (int i = 0; i < 3; i++)
      chk("R10 byte order", {8'd0, pay_log[base + i]}, {8'd0, 8'hA1 + 8'(i)});
    chk("R10 done count", 16'(done_cnt), 16'd1);
    base = pay_cnt;
    wr(8'hBC, 16'd1); word(1'b0, 8'hBF); word(1'b1, 8'h77); word(1'b1, 8'h78);
    chk("R10 single byte", 16'(pay_cnt - base), 16'd1);
    chk("R10 single byte value", {8'd0, pay_log[base]}, 16'h0077);
    chk("R10 single done", 16'(done_cnt), 16'd2);

    wr(8'hC0, 16'h0200); rd(8'hB5, v); chk("R8 other value no reset", v, 16'hB576);
    wr(8'hC0, 16'h0100);
    rd(8'hB5, v); chk("R8 soft reset B5", v, 16'h0000);
    rd(8'hE0, v); chk("R8 soft reset E0", v, 16'h0000);
    rd(8'hDE, v); chk("R8 soft reset lane", v, 16'h0000);
    rd(8'hC0, v); chk("R8 control kept", v, 16'h0100);
    rd(8'hB0, v); chk("R8 id kept", v, 16'h5A31);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule